// File: doc/BRIEF.md
# Scanline Work-RAM Refresh Stall Generator

This block schedules one refresh burst of the main work RAM on every scanline. It watches the horizontal dot position from the raster timing generator. When that position enters a fixed trigger dot near the middle of the line, the block records a pending request. It then waits for the CPU to report an instruction boundary before it opens the refresh window. If no boundary arrives within a bounded wait, the window opens anyway.

While the window is open, the block holds a stall line toward the bus master, so the CPU and the DMA engine stop. The video counters are not stalled and keep running. Inside the window the block issues a fixed number of evenly spaced row strobes. Each strobe carries a row address from a counter that rotates through the configured number of rows. A pending request is dropped when a new line begins, so a request never carries over into the next line.

Top module: `refresh_stall_gen`

## Requirements
- R1: After reset, `cpu_stall` and `row_stb` are 0 and `row_addr` is 0.
- R2: A request is recorded only in the cycle in which `dot_pos` changes to `TRIG_DOT` (default 134) from a different value. Holding `dot_pos` at `TRIG_DOT` for more cycles raises no further request.
- R3: While a request is pending, `insn_done` = 1 at a clock edge starts the window, and `cpu_stall` reads 1 from that edge on. This means one clock after the request was recorded at the earliest. `insn_done` in the cycle that records the request is not used.
- R4: If `insn_done` stays 0, the window starts at the `MAX_WAIT`-th clock edge after the edge that recorded the request.
- R5: `cpu_stall` stays high for exactly `ACC_CYC*ACC_PER` clocks (default 8*5 = 40). The level of `insn_done` does not change this.
- R6: Each window gives `ACC_PER` one-clock `row_stb` pulses, at window offsets 0, `ACC_CYC`, 2*`ACC_CYC`, and so on. `row_stb` is never high outside the window.
- R7: `row_addr` is the row of the current strobe. It advances by one after each strobe and wraps from `ROWS-1` to 0. It holds its value at all other times, including from one window to the next.
- R8: When `dot_pos` changes to 0 (start of a line), the pending request is cleared. This wins over an `insn_done` in the same cycle, and no window follows for that request.
- R9: `insn_done` with no pending request has no effect: `cpu_stall` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dot_pos | input | DOT_W | Horizontal dot counter from the raster timing generator |
| insn_done | input | 1 | CPU is at an instruction boundary in this cycle |
| cpu_stall | output | 1 | Halts the CPU and DMA while refresh runs |
| row_stb | output | 1 | One-clock refresh row access strobe |
| row_addr | output | ROW_W | Row refreshed by the current strobe |

## Verification
Two events can fall in the same cycle: the line-start clear of a pending request, and an instruction boundary that would start the window. The bench records a request and then, in the very next cycle, moves `dot_pos` to 0 and raises `insn_done`. It expects `cpu_stall` to stay low over a span longer than the timeout while `insn_done` stays high. The next refresh must then start at the row where the previous one ended, which shows that no hidden strobes ran.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  // Next row index, wrapping at lim.
  function automatic int unsigned wrap_inc(int unsigned v, int unsigned lim);
    return (v + 1 >= lim) ? 0 : v + 1;
  endfunction

  // True when window offset c is the first cycle of a row access of length per.
  function automatic logic is_access_slot(int unsigned c, int unsigned per);
    return (c % per) == 0;
  endfunction
endpackage

// File: rtl/rfsh_dot_events.sv
module rfsh_dot_events #(
  parameter int unsigned DOT_W    = 9,
  parameter int unsigned TRIG_DOT = 134
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DOT_W-1:0] dot_pos,
  output logic             trig_evt,
  output logic             line_evt
);
  logic [DOT_W-1:0] dot_q;

  always_ff @(posedge clk) begin
    if (!rst_n) dot_q <= '0;
    else        dot_q <= dot_pos;
  end

  assign trig_evt = (dot_pos == DOT_W'(TRIG_DOT)) && (dot_q != DOT_W'(TRIG_DOT));
  assign line_evt = (dot_pos == '0) && (dot_q != '0);
endmodule

// File: rtl/rfsh_arbiter.sv
module rfsh_arbiter #(
  parameter int unsigned MAX_WAIT = 48,
  localparam int unsigned WAIT_W  = $clog2(MAX_WAIT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_evt,
  input  logic              line_evt,
  input  logic              insn_done,
  input  logic              busy,
  output logic              start,
  output logic              pend,
  output logic [WAIT_W-1:0] wait_cnt
);
  logic              pend_q;
  logic [WAIT_W-1:0] wait_q;
  logic              timeout;

  assign timeout = (wait_q == WAIT_W'(MAX_WAIT - 1));
  assign start   = pend_q && !busy && !line_evt && (insn_done || timeout);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      wait_q <= '0;
    end else if (line_evt) begin
      pend_q <= 1'b0;
      wait_q <= '0;
    end else if (trig_evt) begin
      pend_q <= 1'b1;
      wait_q <= '0;
    end else if (start) begin
      pend_q <= 1'b0;
      wait_q <= '0;
    end else if (pend_q && !timeout) begin
      wait_q <= wait_q + 1'b1;
    end
  end

  assign pend     = pend_q;
  assign wait_cnt = wait_q;
endmodule

// File: rtl/rfsh_window.sv
module rfsh_window #(
  parameter int unsigned ACC_CYC = 8,
  parameter int unsigned ACC_PER = 5,
  localparam int unsigned WIN    = ACC_CYC * ACC_PER,
  localparam int unsigned CNT_W  = $clog2(WIN)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active,
  output logic strobe
);
  import rfsh_pkg::*;
  logic [CNT_W-1:0] cnt_q;
  logic             act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      act_q <= 1'b1;
      cnt_q <= '0;
    end else if (act_q) begin
      if (cnt_q == CNT_W'(WIN - 1)) begin
        act_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign active = act_q;
  assign strobe = act_q && is_access_slot(32'(cnt_q), ACC_CYC);
endmodule

// File: rtl/rfsh_rowctr.sv
module rfsh_rowctr #(
  parameter int unsigned ROWS = 256,
  localparam int unsigned ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [ROW_W-1:0] row
);
  import rfsh_pkg::*;
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   row_q <= '0;
    else if (adv) row_q <= ROW_W'(wrap_inc(32'(row_q), ROWS));
  end

  assign row = row_q;
endmodule

// File: rtl/refresh_stall_gen.sv
module refresh_stall_gen #(
  parameter int unsigned DOT_W    = 9,
  parameter int unsigned TRIG_DOT = 134,
  parameter int unsigned MAX_WAIT = 48,
  parameter int unsigned ACC_CYC  = 8,
  parameter int unsigned ACC_PER  = 5,
  parameter int unsigned ROWS     = 256,
  localparam int unsigned ROW_W   = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int unsigned WAIT_W  = $clog2(MAX_WAIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DOT_W-1:0] dot_pos,
  input  logic             insn_done,
  output logic             cpu_stall,
  output logic             row_stb,
  output logic [ROW_W-1:0] row_addr
);
  // Named internal events, observed by the bound checker.
  logic              trig_w;
  logic              line_w;
  logic              start_w;
  logic              pend_w;
  logic              active_w;
  logic              strobe_w;
  logic [WAIT_W-1:0] wait_w;

  rfsh_dot_events #(.DOT_W(DOT_W), .TRIG_DOT(TRIG_DOT)) u_ev (
    .clk(clk), .rst_n(rst_n), .dot_pos(dot_pos),
    .trig_evt(trig_w), .line_evt(line_w)
  );

  rfsh_arbiter #(.MAX_WAIT(MAX_WAIT)) u_arb (
    .clk(clk), .rst_n(rst_n), .trig_evt(trig_w), .line_evt(line_w),
    .insn_done(insn_done), .busy(active_w), .start(start_w),
    .pend(pend_w), .wait_cnt(wait_w)
  );

  rfsh_window #(.ACC_CYC(ACC_CYC), .ACC_PER(ACC_PER)) u_win (
    .clk(clk), .rst_n(rst_n), .start(start_w),
    .active(active_w), .strobe(strobe_w)
  );

  rfsh_rowctr #(.ROWS(ROWS)) u_row (
    .clk(clk), .rst_n(rst_n), .adv(strobe_w), .row(row_addr)
  );

  assign cpu_stall = active_w;
  assign row_stb   = strobe_w;
endmodule

// File: rtl/refresh_stall_gen_chk.sv
module refresh_stall_gen_chk #(
  parameter int unsigned MAX_WAIT = 48,
  parameter int unsigned ACC_CYC  = 8,
  parameter int unsigned ACC_PER  = 5,
  parameter int unsigned ROWS     = 256,
  parameter int unsigned ROW_W    = 8,
  parameter int unsigned WAIT_W   = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_stall,
  input logic             row_stb,
  input logic [ROW_W-1:0] row_addr,
  input logic             pend_w,
  input logic [WAIT_W-1:0] wait_w
);
  localparam int unsigned WIN = ACC_CYC * ACC_PER;
  int unsigned stall_len;
  int unsigned stb_num;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stall_len <= 0;
      stb_num   <= 0;
    end else if (cpu_stall) begin
      stall_len <= stall_len + 1;
      stb_num   <= stb_num + (row_stb ? 1 : 0);
    end else begin
      stall_len <= 0;
      stb_num   <= 0;
    end
  end

  assert_stall_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_stall |-> stall_len < WIN);
  assert_stall_exact_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_stall) |-> stall_len == WIN);
  assert_strobe_inside_R6: assert property (@(posedge clk) disable iff (!rst_n)
    row_stb |-> cpu_stall);
  assert_strobe_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_stall) |-> stb_num == ACC_PER);
  assert_row_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !row_stb |=> $stable(row_addr));
  assert_row_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (row_stb && row_addr == ROW_W'(ROWS - 1)) |=> row_addr == '0);
  assert_start_needs_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_stall) |-> $past(pend_w));
  assert_wait_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pend_w |-> wait_w < WAIT_W'(MAX_WAIT));
endmodule

bind refresh_stall_gen refresh_stall_gen_chk #(
  .MAX_WAIT(MAX_WAIT), .ACC_CYC(ACC_CYC), .ACC_PER(ACC_PER),
  .ROWS(ROWS), .ROW_W(ROW_W), .WAIT_W(WAIT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_stall(cpu_stall), .row_stb(row_stb),
  .row_addr(row_addr), .pend_w(pend_w), .wait_w(wait_w)
);

// File: tb/refresh_stall_gen_test.sv
`timescale 1ns/1ps
module refresh_stall_gen_test;
  localparam int TRIG = 134;
  localparam int MW   = 20;
  localparam int AC   = 8;
  localparam int AP   = 5;
  localparam int NR   = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] dot_pos = '0;
  logic       insn_done = 1'b0;
  logic       cpu_stall;
  logic       row_stb;
  logic [2:0] row_addr;

  int checks = 0;
  int fails  = 0;
  int exp_row = 0;

  always #5 clk = ~clk;

  refresh_stall_gen #(.DOT_W(9), .TRIG_DOT(TRIG), .MAX_WAIT(MW),
    .ACC_CYC(AC), .ACC_PER(AP), .ROWS(NR)) uut (
    .clk(clk), .rst_n(rst_n), .dot_pos(dot_pos), .insn_done(insn_done),
    .cpu_stall(cpu_stall), .row_stb(row_stb), .row_addr(row_addr)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Raise the trigger dot, then start the window by boundary or by timeout.
  // Checks the start latency (R3/R4), window length (R5), strobes (R6), rows (R7).
  task automatic run_refresh(bit use_bnd);
    int lat = 0;
    int idx = 0;
    int stbs = 0;
    @(negedge clk); dot_pos = 9'(TRIG - 1); insn_done = 1'b0;
    @(negedge clk); dot_pos = 9'(TRIG);
    while (lat < 200) begin
      @(negedge clk); lat++;
      if (lat == 1 && use_bnd) begin
        chk("R3 no stall before boundary", int'(cpu_stall), 0);
        insn_done = 1'b1;
      end
      if (cpu_stall) break;
    end
    insn_done = 1'b0;
    if (use_bnd) chk("R3 boundary start latency", lat, 2);
    else         chk("R4 timeout start latency", lat, MW + 1);
    while (cpu_stall && idx < 200) begin
      if (row_stb) begin
        chk("R6 strobe offset", idx % AC, 0);
        chk("R7 strobe row", int'(row_addr), exp_row);
        exp_row = (exp_row + 1) % NR;
        stbs++;
      end
      if (idx == 3) insn_done = 1'b1;   // boundary inside window must not matter
      idx++;
      @(negedge clk);
    end
    insn_done = 1'b0;
    chk("R5 stall length", idx, AC * AP);
    chk("R6 strobe count", stbs, AP);
    chk("R7 row after window", int'(row_addr), exp_row);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 stall at reset", int'(cpu_stall), 0);
    chk("R1 strobe at reset", int'(row_stb), 0);
    chk("R1 row at reset", int'(row_addr), 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // R2: dot held at trigger after a window gives no second request.
  task automatic t_hold_trigger;
    int seen = 0;
    for (int i = 0; i < MW + 10; i++) begin
      @(negedge clk);
      if (cpu_stall) seen++;
    end
    chk("R2 held trigger dot no re-request", seen, 0);
  endtask

  // R9: boundaries with nothing pending.
  task automatic t_idle_boundary;
    int seen = 0;
    @(negedge clk); dot_pos = 9'd50; insn_done = 1'b1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (cpu_stall) seen++;
    end
    insn_done = 1'b0;
    chk("R9 idle boundary ignored", seen, 0);
  endtask

  // R8: line start in the same cycle as a boundary that could start the window.
  task automatic t_line_cancel;
    int seen = 0;
    @(negedge clk); dot_pos = 9'(TRIG - 1);
    @(negedge clk); dot_pos = 9'(TRIG);
    @(negedge clk); dot_pos = 9'd0; insn_done = 1'b1;
    for (int i = 0; i < MW + 10; i++) begin
      @(negedge clk);
      if (cpu_stall) seen++;
    end
    insn_done = 1'b0;
    chk("R8 line start drops request", seen, 0);
    chk("R8 row untouched", int'(row_addr), exp_row);
  endtask

  initial begin
    t_reset();
    run_refresh(1'b1);   // rows 0..4
    t_hold_trigger();
    run_refresh(1'b0);   // rows 5,0,1,2,3 (wrap)
    t_idle_boundary();
    t_line_cancel();
    run_refresh(1'b1);   // continues at row 4
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule